// File: doc/BRIEF.md
# Key-Protected Clock and Power Controller

This block governs the core clock of a small microcontroller. It sits on a simple register write bus and holds two guarded registers. The clock-source register picks where the system clock comes from. The power register sets a binary divide factor and an operating mode. Neither register can be changed by a lone write. Each accepts new data only when that data is framed by an opening key and a closing key, written to the register's own key address with no other bus write in between.

The core does not get a second clock. It gets a one-cycle enable pulse, `core_ce`, derived from the fast clock and asserted once every 2^CD cycles. This pulse is held low in two cases: while the core naps, and while the PLL reports loss of lock. A lock loss also raises `pll_irq`.

A new clock source is not applied when its register is written. It waits until the core is woken out of nap by an interrupt request. The PLL, the oscillators and the interrupt sources lie outside the block and appear only as the `pll_lock` and `wake_irq` inputs.

The register bus is a plain write strobe with address and data. Every write is accepted in the cycle it is presented, so there is no valid/ready handshake and no back-pressure. All outputs are plain status or enable pins.

Top module: `clkpwr_ctrl`

## Requirements
- R1: After reset, `src_sel` is 00, `cd_val` is 3, `nap` is 0 and `pll_irq` is 0. The first `core_ce` pulses are 8 cycles apart.
- R2: While locked and not napping, `core_ce` is a single-cycle pulse repeating every 2^CD clock cycles, for every CD value 0 to 7.
- R3: A new CD value is taken up by the divider only at its next terminal count. The interval in progress keeps its old length, and the interval after it uses the new length.
- R4: The clock-source register (data address 1) is written only by this exact sequence: a write of 0xAA to address 0, then the data write to address 1, then a write of 0x55 to address 0. A wrong key changes nothing.
- R5: The power register (data address 3) is written only by this exact sequence: a write of 0x01 to address 2, then the data write to address 3, then a write of 0xF4 to address 2. The new value shows on `cd_val` after the edge that takes the closing key.
- R6: Any bus write that breaks a sequence aborts it. This includes a write to another address and a wrong closing key. The register keeps its old value, and the very next correct sequence succeeds.
- R7: In the power register, bits [2:0] are CD and bits [6:4] are the mode. Mode 010 is nap, and every other mode value is active. Writing 0x27 gives nap with CD 7.
- R8: While `nap` is high, `core_ce` stays low.
- R9: `wake_irq` high while napping clears `nap` at the next edge and returns the mode to active.
- R10: Bits [1:0] of the clock-source register select the source: 00 is the internal PLL, 01 is the crystal, and 11 is the external clock input. A committed value is held pending. It reaches `src_sel` only at a wake-up from nap. `wake_irq` outside nap leaves `src_sel` unchanged.
- R11: When `pll_lock` is low, `core_ce` is low in the same cycle. `pll_irq` is high from the next edge for as long as lock is lost and drops one edge after lock returns. `core_ce` then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Write address: 0 clock key, 1 clock data, 2 power key, 3 power data |
| bus_wdata | input | 8 | Write data |
| pll_lock | input | 1 | PLL lock indication |
| wake_irq | input | 1 | Enabled interrupt request used to leave nap |
| core_ce | output | 1 | Divided core clock enable pulse |
| src_sel | output | 2 | Clock source in effect |
| cd_val | output | 3 | Divider field of the power register |
| nap | output | 1 | Core is in nap mode |
| pll_irq | output | 1 | PLL lock-loss interrupt request |

## Verification
The divider is timed for all eight CD values. A controller that counted off by one, or applied CD at the wrong point, would show the wrong spacing or a truncated interval right after a CD change.

Key sequences are broken with a wrong opening key, a wrong closing key and an intruding write. A controller that let a stray write through, or stayed half-unlocked after an abort, would alter `cd_val` or the eventual `src_sel`, or would refuse the following good sequence.

The clock-source change is checked before and after a wake-up. A spurious `wake_irq` outside nap is also applied. A controller that switched early, or on any interrupt, would move `src_sel` too soon.

Lock loss is raised while the divider runs at full rate. Any leak of `core_ce`, or a stuck `pll_irq`, is then visible at once.

// File: rtl/clkpwr_pkg.sv
package clkpwr_pkg;
  localparam int CDW = 3;
  localparam int AW  = 2;
  localparam int DW  = 8;

  localparam logic [AW-1:0] ADDR_CLK_KEY = 2'd0;
  localparam logic [AW-1:0] ADDR_CLK_DAT = 2'd1;
  localparam logic [AW-1:0] ADDR_PWR_KEY = 2'd2;
  localparam logic [AW-1:0] ADDR_PWR_DAT = 2'd3;

  localparam logic [2:0] MODE_ACTIVE = 3'b000;
  localparam logic [2:0] MODE_NAP    = 3'b010;

  typedef enum logic [1:0] {
    UL_IDLE   = 2'd0,
    UL_KEYED  = 2'd1,
    UL_LOADED = 2'd2
  } unlock_st_t;
endpackage

// File: rtl/keyseq_unlock.sv
module keyseq_unlock
  import clkpwr_pkg::*;
#(
  parameter int            W_A       = 2,
  parameter int            W_D       = 8,
  parameter logic [W_A-1:0] KEY_ADDR  = '0,
  parameter logic [W_A-1:0] DATA_ADDR = '0,
  parameter logic [W_D-1:0] KEY_OPEN  = '0,
  parameter logic [W_D-1:0] KEY_CLOSE = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [W_A-1:0] addr,
  input  logic [W_D-1:0] wdata,
  output logic           commit,
  output logic [W_D-1:0] staged
);
  unlock_st_t st;

  // Any write in a non-idle state either advances or aborts to idle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= UL_IDLE;
      staged <= '0;
    end else if (wr) begin
      unique case (st)
        UL_IDLE:   st <= (addr == KEY_ADDR && wdata == KEY_OPEN) ? UL_KEYED : UL_IDLE;
        UL_KEYED: begin
          if (addr == DATA_ADDR) begin
            staged <= wdata;
            st     <= UL_LOADED;
          end else begin
            st <= UL_IDLE;
          end
        end
        default:   st <= UL_IDLE;
      endcase
    end
  end

  assign commit = wr && (st == UL_LOADED) && (addr == KEY_ADDR) && (wdata == KEY_CLOSE);
endmodule

// File: rtl/ce_divider.sv
module ce_divider #(
  parameter int             W_CD   = 3,
  parameter logic [W_CD-1:0] RST_CD = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W_CD-1:0] cd,
  output logic            tick
);
  localparam int CW = (1 << W_CD) - 1;
  localparam logic [CW-1:0] ONE = 1;

  logic [CW-1:0]   cnt;
  logic [CW-1:0]   lim;
  logic [W_CD-1:0] cd_lat;

  assign lim  = (ONE << cd_lat) - ONE;
  assign tick = (cnt == lim);

  // The divide factor is sampled only at terminal count.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      cd_lat <= RST_CD;
    end else if (tick) begin
      cnt    <= '0;
      cd_lat <= cd;
    end else begin
      cnt <= cnt + ONE;
    end
  end
endmodule

// File: rtl/clkpwr_ctrl.sv
module clkpwr_ctrl
  import clkpwr_pkg::*;
#(
  parameter logic [DW-1:0]  CLK_KEY_OPEN  = 8'hAA,
  parameter logic [DW-1:0]  CLK_KEY_CLOSE = 8'h55,
  parameter logic [DW-1:0]  PWR_KEY_OPEN  = 8'h01,
  parameter logic [DW-1:0]  PWR_KEY_CLOSE = 8'hF4,
  parameter logic [CDW-1:0] RST_CD        = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  input  logic           pll_lock,
  input  logic           wake_irq,
  output logic           core_ce,
  output logic [1:0]     src_sel,
  output logic [CDW-1:0] cd_val,
  output logic           nap,
  output logic           pll_irq
);
  logic          clk_commit, pwr_commit;
  logic [DW-1:0] clk_staged, pwr_staged;
  logic [2:0]    mode_q;
  logic [1:0]    pend_src;
  logic          pend_vld;
  logic          div_tick;
  logic          wake_go;

  keyseq_unlock #(
    .W_A(AW), .W_D(DW), .KEY_ADDR(ADDR_CLK_KEY), .DATA_ADDR(ADDR_CLK_DAT),
    .KEY_OPEN(CLK_KEY_OPEN), .KEY_CLOSE(CLK_KEY_CLOSE)
  ) u_clk_unlock (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .commit(clk_commit), .staged(clk_staged)
  );

  keyseq_unlock #(
    .W_A(AW), .W_D(DW), .KEY_ADDR(ADDR_PWR_KEY), .DATA_ADDR(ADDR_PWR_DAT),
    .KEY_OPEN(PWR_KEY_OPEN), .KEY_CLOSE(PWR_KEY_CLOSE)
  ) u_pwr_unlock (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .commit(pwr_commit), .staged(pwr_staged)
  );

  assign nap     = (mode_q == MODE_NAP);
  assign wake_go = nap && wake_irq;

  // Power register: a committed write wins over a same-cycle wake.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_ACTIVE;
      cd_val <= RST_CD;
    end else if (pwr_commit) begin
      mode_q <= pwr_staged[6:4];
      cd_val <= pwr_staged[CDW-1:0];
    end else if (wake_go) begin
      mode_q <= MODE_ACTIVE;
    end
  end

  // Clock source: committed value waits for a wake-up from nap.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_sel  <= 2'b00;
      pend_src <= 2'b00;
      pend_vld <= 1'b0;
    end else begin
      if (wake_go && pend_vld) src_sel <= pend_src;
      if (clk_commit) begin
        pend_src <= clk_staged[1:0];
        pend_vld <= 1'b1;
      end else if (wake_go) begin
        pend_vld <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pll_irq <= 1'b0;
    else        pll_irq <= !pll_lock;
  end

  ce_divider #(.W_CD(CDW), .RST_CD(RST_CD)) u_div (
    .clk(clk), .rst_n(rst_n), .cd(cd_val), .tick(div_tick)
  );

  assign core_ce = div_tick && pll_lock && !nap;
endmodule

// File: rtl/clkpwr_chk.sv
module clkpwr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       pll_lock,
  input logic       wake_irq,
  input logic       core_ce,
  input logic [1:0] src_sel,
  input logic [2:0] cd_val,
  input logic       nap,
  input logic       pll_irq
);
  a_r8_nap_gates_ce: assert property (@(posedge clk) disable iff (!rst_n)
    nap |-> !core_ce);

  a_r11_unlock_gates_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_lock |-> !core_ce);

  a_r11_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_lock |=> pll_irq);

  a_r11_irq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    pll_lock |=> !pll_irq);

  a_r10_src_only_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (!nap || !wake_irq) |=> $stable(src_sel));

  a_r9_wake_leaves_nap: assert property (@(posedge clk) disable iff (!rst_n)
    (nap && wake_irq && !bus_wr) |=> !nap);

  a_r5_cd_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(cd_val));
endmodule

bind clkpwr_ctrl clkpwr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .pll_lock(pll_lock),
  .wake_irq(wake_irq), .core_ce(core_ce), .src_sel(src_sel), .cd_val(cd_val),
  .nap(nap), .pll_irq(pll_irq)
);

// File: tb/sim_clkpwr_ctrl.sv
`timescale 1ns/1ps
module sim_clkpwr_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       pll_lock = 1'b1;
  logic       wake_irq = 1'b0;
  logic       core_ce;
  logic [1:0] src_sel;
  logic [2:0] cd_val;
  logic       nap;
  logic       pll_irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clkpwr_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pll_lock(pll_lock), .wake_irq(wake_irq),
    .core_ce(core_ce), .src_sel(src_sel), .cd_val(cd_val), .nap(nap),
    .pll_irq(pll_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic clk_seq(input logic [7:0] k1, input logic [7:0] d, input logic [7:0] k2);
    bus_write(2'd0, k1); bus_write(2'd1, d); bus_write(2'd0, k2);
  endtask

  task automatic pwr_seq(input logic [7:0] k1, input logic [7:0] d, input logic [7:0] k2);
    bus_write(2'd2, k1); bus_write(2'd3, d); bus_write(2'd2, k2);
  endtask

  task automatic wait_ce(output int at);
    at = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (core_ce) begin at = cyc; break; end
    end
    if (at < 0) check(1'b0, "R2 ce timeout", 0, 1);
  endtask

  task automatic wake_pulse();
    wake_irq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wake_irq = 1'b0;
  endtask

  task automatic count_ce(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (core_ce) hits++;
    end
  endtask

  task automatic t_reset();
    int t0, t1;
    check(src_sel == 2'b00, "R1 src", src_sel, 0);
    check(cd_val == 3'd3, "R1 cd", cd_val, 3);
    check(nap == 1'b0, "R1 nap", nap, 0);
    check(pll_irq == 1'b0, "R1 irq", pll_irq, 0);
    wait_ce(t0); wait_ce(t1);
    check(t1 - t0 == 8, "R1 reset period", t1 - t0, 8);
  endtask

  task automatic t_ratios();
    int t0, t1;
    for (int k = 0; k < 8; k++) begin
      pwr_seq(8'h01, 8'(k), 8'hF4);
      check(cd_val == 3'(k), "R5 cd write", cd_val, k);
      wait_ce(t0); wait_ce(t1);
      check(t1 - t0 == (1 << k), "R2 period", t1 - t0, 1 << k);
    end
  endtask

  task automatic t_cd_timing();
    int t0, t1, t2;
    pwr_seq(8'h01, 8'h03, 8'hF4);
    wait_ce(t0); wait_ce(t0); wait_ce(t0);
    pwr_seq(8'h01, 8'h00, 8'hF4);
    wait_ce(t1); wait_ce(t2);
    check(t1 - t0 == 8, "R3 old interval kept", t1 - t0, 8);
    check(t2 - t1 == 1, "R3 new interval", t2 - t1, 1);
  endtask

  task automatic t_pwr_abort();
    pwr_seq(8'h02, 8'h05, 8'hF4);
    check(cd_val == 3'd0, "R6 wrong open key", cd_val, 0);
    pwr_seq(8'h01, 8'h05, 8'hF5);
    check(cd_val == 3'd0, "R6 wrong close key", cd_val, 0);
    bus_write(2'd2, 8'h01); bus_write(2'd0, 8'hAA);
    bus_write(2'd3, 8'h05); bus_write(2'd2, 8'hF4);
    check(cd_val == 3'd0, "R6 intruding write", cd_val, 0);
    pwr_seq(8'h01, 8'h05, 8'hF4);
    check(cd_val == 3'd5, "R6 recovery", cd_val, 5);
  endtask

  task automatic t_modes();
    pwr_seq(8'h01, 8'h35, 8'hF4);
    check(nap == 1'b0 && cd_val == 3'd5, "R7 mode 011 active", nap, 0);
    pwr_seq(8'h01, 8'h72, 8'hF4);
    check(nap == 1'b0 && cd_val == 3'd2, "R7 mode 111 active", nap, 0);
    pwr_seq(8'h01, 8'h27, 8'hF4);
    check(nap == 1'b1, "R7 nap entry", nap, 1);
    check(cd_val == 3'd7, "R7 nap cd", cd_val, 7);
    wake_pulse();
    check(nap == 1'b0, "R9 wake", nap, 0);
  endtask

  task automatic t_switch();
    int hits;
    pwr_seq(8'h01, 8'h00, 8'hF4);
    clk_seq(8'hAA, 8'h01, 8'h55);
    check(src_sel == 2'b00, "R10 held pending", src_sel, 0);
    wake_pulse();
    check(src_sel == 2'b00, "R10 wake outside nap", src_sel, 0);
    pwr_seq(8'h01, 8'h20, 8'hF4);
    count_ce(300, hits);
    check(hits == 0, "R8 nap gates ce", hits, 0);
    check(src_sel == 2'b00, "R10 pending in nap", src_sel, 0);
    wake_pulse();
    check(nap == 1'b0, "R9 wake exits nap", nap, 0);
    check(src_sel == 2'b01, "R10 crystal applied", src_sel, 1);
    clk_seq(8'hAB, 8'h03, 8'h55);
    clk_seq(8'hAA, 8'h03, 8'h54);
    bus_write(2'd0, 8'hAA); bus_write(2'd2, 8'h01);
    bus_write(2'd1, 8'h03); bus_write(2'd0, 8'h55);
    pwr_seq(8'h01, 8'h20, 8'hF4);
    wake_pulse();
    check(src_sel == 2'b01, "R4 corrupted sequences rejected", src_sel, 1);
    clk_seq(8'hAA, 8'h03, 8'h55);
    pwr_seq(8'h01, 8'h20, 8'hF4);
    wake_pulse();
    check(src_sel == 2'b11, "R4 external clock applied", src_sel, 3);
  endtask

  task automatic t_pll();
    int hits, t0;
    pll_lock = 1'b0;
    #1;
    check(core_ce == 1'b0, "R11 immediate gate", core_ce, 0);
    @(negedge clk);
    check(pll_irq == 1'b1, "R11 irq raised", pll_irq, 1);
    count_ce(50, hits);
    check(hits == 0, "R11 gated while unlocked", hits, 0);
    check(pll_irq == 1'b1, "R11 irq held", pll_irq, 1);
    pll_lock = 1'b1;
    @(negedge clk);
    check(pll_irq == 1'b0, "R11 irq cleared", pll_irq, 0);
    wait_ce(t0);
    check(t0 >= 0, "R11 ce resumes", t0, 1);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ratios();
    t_cd_timing();
    t_pwr_abort();
    t_modes();
    t_switch();
    t_pll();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule